// File: doc/BRIEF.md
# Link Flow-Control Initialisation Controller

This block is the link-layer control state machine that takes a serial link from inactive to active once the physical layer reports that training has finished. It runs a two-phase credit handshake with the link partner. In each phase it keeps sending one credit advertisement per cycle for the posted, non-posted and completion categories, in that rotating order. It listens for the partner's advertisements of the same phase. In the first phase it records the partner's header and data credit values for each category.

Received link packets arrive already decoded, with a flag that says whether their CRC was good. Transmitted advertisements leave as field values; framing and CRC generation belong to a later stage. When both phases are complete, the block raises a link-active status for the transaction layer. A drop of the physical link-up returns it to the inactive state from anywhere and discards what it learnt.

Top module: `fc_link_init`

## Requirements
- R1: While reset is held and in the first cycle after it, `dl_up` and `tx_valid` are 0 and both partner credit buses are all zero.
- R2: In the inactive state, a clock edge that samples `phy_link_up`=1 enters the first phase, and the first advertisement emitted is the posted one.
- R3: In the first phase one advertisement is emitted per cycle, rotating posted, non-posted, completion, with kind codes 4'b0100, 4'b0101 and 4'b0110.
- R4: Each advertisement carries `tx_vc`=`VC_ID`. Its header and data credits are the local values of the category being advertised. On the local buses the posted value sits in the lowest slice, then non-posted, then completion, with 8 bits per header slice and 12 bits per data slice.
- R5: A received packet is accepted only if `rx_valid`, `rx_crc_ok`, `rx_vc`=`VC_ID` and a first-phase kind code all hold while the block is in the first phase. Only the first accepted advertisement of each category is recorded, and later ones leave the recorded values unchanged. Recorded values appear on `par_hdr_cred`/`par_dat_cred`, in the same slice layout as the local buses, one edge after acceptance.
- R6: The first phase ends at the edge closing a completion emission, provided all three partner categories were already recorded when that cycle began. The second phase then emits kind codes 4'b1100, 4'b1101 and 4'b1110 in the same rotation, starting with posted.
- R7: The active state is entered at the edge where all three second-phase advertisements have been emitted and all three of the partner's have been received with good CRC and matching channel, counting that cycle. The active state has `dl_up`=1 and `tx_valid`=0.
- R8: `par_hdr_inf[i]` and `par_dat_inf[i]` are 1 exactly when the recorded partner value of category i (0 posted, 1 non-posted, 2 completion) is zero, the code for unlimited credit.
- R9: An edge sampling `phy_link_up`=0 returns the block to the inactive state from any state and clears the recorded partner credits and progress. After that edge `dl_up` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_link_up | input | 1 | Physical layer reports trained link |
| loc_hdr_cred | input | 24 | Local header credits, three 8-bit slices (P, NP, Cpl from LSB) |
| loc_dat_cred | input | 36 | Local data credits, three 12-bit slices (P, NP, Cpl from LSB) |
| rx_valid | input | 1 | A decoded link packet is present |
| rx_crc_ok | input | 1 | Its 16-bit CRC checked good |
| rx_kind | input | 4 | Received packet kind code |
| rx_vc | input | 3 | Received channel identifier |
| rx_hdr | input | 8 | Received header credit value |
| rx_dat | input | 12 | Received data credit value |
| tx_valid | output | 1 | An advertisement is being sent this cycle |
| tx_kind | output | 4 | Kind code of the advertisement |
| tx_vc | output | 3 | Channel identifier of the advertisement |
| tx_hdr | output | 8 | Header credit value advertised |
| tx_dat | output | 12 | Data credit value advertised |
| par_hdr_cred | output | 24 | Recorded partner header credits |
| par_dat_cred | output | 36 | Recorded partner data credits |
| par_hdr_inf | output | 3 | Partner header credit unlimited, per category |
| par_dat_inf | output | 3 | Partner data credit unlimited, per category |
| dl_up | output | 1 | Link layer active |

## Verification
Every transmit field and `dl_up` is decoded from registered state, so each result belongs to the cycle after the edge that consumed its stimulus. Captured partner credits follow the accepting edge by one cycle as well. The bench drives each stimulus at a falling edge and lets exactly one rising edge pass. It then compares outputs at the next falling edge, so each expected value in its table describes the state one edge later. Phase changes are checked in the cycle that follows the deciding emission, and partner records are read in the cycle after the packet was offered.

// File: rtl/fci_pkg.sv
package fci_pkg;

    localparam int NCAT   = 3;
    localparam int HDR_W  = 8;
    localparam int DAT_W  = 12;
    localparam int KIND_W = 4;
    localparam int VC_W   = 3;

    localparam logic [NCAT-1:0] ALL_CATS = '1;

    typedef enum logic [1:0] {
        ST_INACT  = 2'd0,
        ST_INIT1  = 2'd1,
        ST_INIT2  = 2'd2,
        ST_ACTIVE = 2'd3
    } dl_state_e;

    typedef enum logic [1:0] {
        CAT_P   = 2'd0,
        CAT_NP  = 2'd1,
        CAT_CPL = 2'd2
    } fc_cat_e;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [VC_W-1:0]   vc;
        logic [HDR_W-1:0]  hdr;
        logic [DAT_W-1:0]  dat;
    } fc_dllp_t;

    // Advertisement kind: bit3 selects phase, bit2 marks an init advert,
    // bits1:0 carry the category.
    function automatic logic [KIND_W-1:0] adv_kind(logic second, fc_cat_e c);
        return {second, 1'b1, c};
    endfunction

    function automatic logic is_adv(logic [KIND_W-1:0] k);
        return k[2] && (k[1:0] != 2'b11);
    endfunction

    function automatic fc_cat_e next_cat(fc_cat_e c);
        fc_cat_e n;
        case (c)
            CAT_P:   n = CAT_NP;
            CAT_NP:  n = CAT_CPL;
            default: n = CAT_P;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fci_adv_seq.sv
module fci_adv_seq
    import fci_pkg::*;
#(
    parameter logic [VC_W-1:0] VC_ID = '0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    restart,
    input  logic                    emit,
    input  logic                    second,
    input  logic [NCAT*HDR_W-1:0]   loc_hdr,
    input  logic [NCAT*DAT_W-1:0]   loc_dat,
    output fc_cat_e                 cat,
    output fc_dllp_t                adv
);

    fc_cat_e cat_q;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cat_q <= CAT_P;
        else if (emit)
            cat_q <= next_cat(cat_q);
    end

    always_comb begin
        adv.kind = adv_kind(second, cat_q);
        adv.vc   = VC_ID;
        adv.hdr  = loc_hdr[int'(cat_q)*HDR_W +: HDR_W];
        adv.dat  = loc_dat[int'(cat_q)*DAT_W +: DAT_W];
    end

    assign cat = cat_q;

endmodule

// File: rtl/fci_rx_track.sv
module fci_rx_track
    import fci_pkg::*;
#(
    parameter logic [VC_W-1:0] VC_ID = '0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    take1,
    input  logic                    take2,
    input  logic                    rx_valid,
    input  logic                    rx_crc_ok,
    input  fc_dllp_t                rx,
    output logic [NCAT-1:0]         seen1,
    output logic [NCAT-1:0]         seen2,
    output logic [NCAT-1:0]         hit2,
    output logic [NCAT*HDR_W-1:0]   par_hdr,
    output logic [NCAT*DAT_W-1:0]   par_dat
);

    logic good;
    assign good = rx_valid && rx_crc_ok && (rx.vc == VC_ID) && is_adv(rx.kind);

    for (genvar g = 0; g < NCAT; g++) begin : g_cat
        logic             sel;
        logic             hit1;
        logic             s1_q, s2_q;
        logic [HDR_W-1:0] h_q;
        logic [DAT_W-1:0] d_q;

        assign sel     = good && (int'(rx.kind[1:0]) == g);
        assign hit1    = sel && !rx.kind[3] && take1;
        assign hit2[g] = sel &&  rx.kind[3] && take2;

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                h_q  <= '0;
                d_q  <= '0;
            end else begin
                if (hit1 && !s1_q) begin
                    s1_q <= 1'b1;
                    h_q  <= rx.hdr;
                    d_q  <= rx.dat;
                end
                if (hit2[g])
                    s2_q <= 1'b1;
            end
        end

        assign seen1[g]                 = s1_q;
        assign seen2[g]                 = s2_q;
        assign par_hdr[g*HDR_W +: HDR_W] = h_q;
        assign par_dat[g*DAT_W +: DAT_W] = d_q;
    end

endmodule

// File: rtl/fc_link_init.sv
module fc_link_init
    import fci_pkg::*;
#(
    parameter logic [VC_W-1:0] VC_ID = '0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    phy_link_up,
    input  logic [NCAT*HDR_W-1:0]   loc_hdr_cred,
    input  logic [NCAT*DAT_W-1:0]   loc_dat_cred,
    input  logic                    rx_valid,
    input  logic                    rx_crc_ok,
    input  logic [KIND_W-1:0]       rx_kind,
    input  logic [VC_W-1:0]         rx_vc,
    input  logic [HDR_W-1:0]        rx_hdr,
    input  logic [DAT_W-1:0]        rx_dat,
    output logic                    tx_valid,
    output logic [KIND_W-1:0]       tx_kind,
    output logic [VC_W-1:0]         tx_vc,
    output logic [HDR_W-1:0]        tx_hdr,
    output logic [DAT_W-1:0]        tx_dat,
    output logic [NCAT*HDR_W-1:0]   par_hdr_cred,
    output logic [NCAT*DAT_W-1:0]   par_dat_cred,
    output logic [NCAT-1:0]         par_hdr_inf,
    output logic [NCAT-1:0]         par_dat_inf,
    output logic                    dl_up
);

    dl_state_e       state_q, state_d;
    fc_cat_e         cat;
    fc_dllp_t        adv, rx_pkt;
    logic            emit, second;
    logic [NCAT-1:0] cat_oh, sent2_q, seen1, seen2, hit2;

    assign emit   = (state_q == ST_INIT1) || (state_q == ST_INIT2);
    assign second = (state_q == ST_INIT2);
    assign cat_oh = NCAT'(1) << int'(cat);
    assign rx_pkt = '{kind: rx_kind, vc: rx_vc, hdr: rx_hdr, dat: rx_dat};

    fci_adv_seq #(.VC_ID(VC_ID)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .restart (!phy_link_up),
        .emit    (emit),
        .second  (second),
        .loc_hdr (loc_hdr_cred),
        .loc_dat (loc_dat_cred),
        .cat     (cat),
        .adv     (adv)
    );

    fci_rx_track #(.VC_ID(VC_ID)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .clear     (!phy_link_up),
        .take1     (state_q == ST_INIT1),
        .take2     (state_q == ST_INIT2),
        .rx_valid  (rx_valid),
        .rx_crc_ok (rx_crc_ok),
        .rx        (rx_pkt),
        .seen1     (seen1),
        .seen2     (seen2),
        .hit2      (hit2),
        .par_hdr   (par_hdr_cred),
        .par_dat   (par_dat_cred)
    );

    // Main control sequence
    always_comb begin
        state_d = state_q;
        if (!phy_link_up) begin
            state_d = ST_INACT;
        end else begin
            case (state_q)
                ST_INACT:  state_d = ST_INIT1;
                ST_INIT1:  if (cat == CAT_CPL && seen1 == ALL_CATS) state_d = ST_INIT2;
                ST_INIT2:  if (((sent2_q | cat_oh) == ALL_CATS) &&
                               ((seen2 | hit2) == ALL_CATS)) state_d = ST_ACTIVE;
                default:   state_d = ST_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_INACT;
            sent2_q <= '0;
        end else begin
            state_q <= state_d;
            sent2_q <= (state_q == ST_INIT2) ? (sent2_q | cat_oh) : '0;
        end
    end

    for (genvar g = 0; g < NCAT; g++) begin : g_inf
        assign par_hdr_inf[g] = (par_hdr_cred[g*HDR_W +: HDR_W] == '0);
        assign par_dat_inf[g] = (par_dat_cred[g*DAT_W +: DAT_W] == '0);
    end

    assign tx_valid = emit;
    assign tx_kind  = adv.kind;
    assign tx_vc    = adv.vc;
    assign tx_hdr   = adv.hdr;
    assign tx_dat   = adv.dat;
    assign dl_up    = (state_q == ST_ACTIVE);

    // R3: a non-posted first-phase advert always follows a posted one
    a_r3_np_after_p: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_kind == 4'b0101) |-> ($past(tx_valid) && $past(tx_kind) == 4'b0100));

    // R5: a packet with a bad CRC never alters the recorded partner credits
    a_r5_bad_crc_ignored: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_crc_ok && phy_link_up) |=>
            ($stable(par_hdr_cred) && $stable(par_dat_cred)));

    // R6: the second phase opens right after a first-phase completion advert
    a_r6_phase2_entry: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_kind == 4'b1100 && $past(tx_valid) && !$past(tx_kind[3])) |->
            ($past(tx_kind) == 4'b0110));

    // R7: link-active is only reached from a second-phase emission cycle
    a_r7_up_from_phase2: assert property (@(posedge clk) disable iff (rst)
        $rose(dl_up) |-> ($past(tx_valid) && $past(tx_kind[3]) && !tx_valid));

    // R9: losing the physical link drops everything on the next edge
    a_r9_link_loss: assert property (@(posedge clk) disable iff (rst)
        !phy_link_up |=> (!dl_up && !tx_valid && par_hdr_cred == '0 && par_dat_cred == '0));

endmodule

// File: tb/tb_fc_link_init.sv
module tb_fc_link_init;

    logic        clk = 1'b0;
    logic        rst;
    logic        phy_link_up;
    logic [23:0] loc_hdr_cred;
    logic [35:0] loc_dat_cred;
    logic        rx_valid, rx_crc_ok;
    logic [3:0]  rx_kind;
    logic [2:0]  rx_vc;
    logic [7:0]  rx_hdr;
    logic [11:0] rx_dat;
    logic        tx_valid;
    logic [3:0]  tx_kind;
    logic [2:0]  tx_vc;
    logic [7:0]  tx_hdr;
    logic [11:0] tx_dat;
    logic [23:0] par_hdr_cred;
    logic [35:0] par_dat_cred;
    logic [2:0]  par_hdr_inf, par_dat_inf;
    logic        dl_up;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fc_link_init #(.VC_ID(3'd0)) dut (
        .clk(clk), .rst(rst), .phy_link_up(phy_link_up),
        .loc_hdr_cred(loc_hdr_cred), .loc_dat_cred(loc_dat_cred),
        .rx_valid(rx_valid), .rx_crc_ok(rx_crc_ok), .rx_kind(rx_kind),
        .rx_vc(rx_vc), .rx_hdr(rx_hdr), .rx_dat(rx_dat),
        .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_vc(tx_vc),
        .tx_hdr(tx_hdr), .tx_dat(tx_dat),
        .par_hdr_cred(par_hdr_cred), .par_dat_cred(par_dat_cred),
        .par_hdr_inf(par_hdr_inf), .par_dat_inf(par_dat_inf), .dl_up(dl_up)
    );

    typedef struct packed {
        logic        lu;
        logic        rv;
        logic        ok;
        logic [3:0]  ty;
        logic [7:0]  hd;
        logic [11:0] dt;
        logic        ev;
        logic [3:0]  et;
        logic        eu;
    } vec_t;

    // Each row: stimulus for one edge, outputs expected after that edge.
    localparam vec_t TBL [0:12] = '{
        '{1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 12'h000, 1'b1, 4'h4, 1'b0},
        '{1'b1, 1'b1, 1'b0, 4'h4, 8'h10, 12'h050, 1'b1, 4'h5, 1'b0},
        '{1'b1, 1'b1, 1'b1, 4'h4, 8'h20, 12'h100, 1'b1, 4'h6, 1'b0},
        '{1'b1, 1'b1, 1'b1, 4'h5, 8'h08, 12'h010, 1'b1, 4'h4, 1'b0},
        '{1'b1, 1'b1, 1'b1, 4'h6, 8'h00, 12'h000, 1'b1, 4'h5, 1'b0},
        '{1'b1, 1'b1, 1'b1, 4'h4, 8'h55, 12'h555, 1'b1, 4'h6, 1'b0},
        '{1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 12'h000, 1'b1, 4'hC, 1'b0},
        '{1'b1, 1'b1, 1'b1, 4'hC, 8'h00, 12'h000, 1'b1, 4'hD, 1'b0},
        '{1'b1, 1'b1, 1'b1, 4'h4, 8'h77, 12'h777, 1'b1, 4'hE, 1'b0},
        '{1'b1, 1'b1, 1'b1, 4'hD, 8'h00, 12'h000, 1'b1, 4'hC, 1'b0},
        '{1'b1, 1'b1, 1'b1, 4'hE, 8'h00, 12'h000, 1'b0, 4'h0, 1'b1},
        '{1'b1, 1'b0, 1'b0, 4'h0, 8'h00, 12'h000, 1'b0, 4'h0, 1'b1},
        '{1'b0, 1'b0, 1'b0, 4'h0, 8'h00, 12'h000, 1'b0, 4'h0, 1'b0}
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge: drive, pass one rising edge, return at falling edge.
    task automatic step(logic lu, logic rv, logic ok, logic [3:0] ty, logic [2:0] vc,
                        logic [7:0] hd, logic [11:0] dt);
        phy_link_up = lu; rx_valid = rv; rx_crc_ok = ok; rx_kind = ty;
        rx_vc = vc; rx_hdr = hd; rx_dat = dt;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string tag_of(int i);
        if (i == 0)  return "R2";
        if (i <= 5)  return "R3";
        if (i <= 9)  return "R6";
        if (i <= 11) return "R7";
        return "R9";
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        loc_hdr_cred = {8'h00, 8'h04, 8'h0C};
        loc_dat_cred = {12'h000, 12'h004, 12'h030};
        rst = 1'b1;
        phy_link_up = 1'b0; rx_valid = 1'b0; rx_crc_ok = 1'b0;
        rx_kind = '0; rx_vc = '0; rx_hdr = '0; rx_dat = '0;
        repeat (3) @(negedge clk);
        // R1: held in reset
        check("R1 dl_up", dl_up, 0);
        check("R1 tx_valid", tx_valid, 0);
        check("R1 par_hdr", par_hdr_cred, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 idle after reset", {dl_up, tx_valid}, 0);
        check("R1 par_dat", par_dat_cred, 0);

        for (int i = 0; i < 13; i++) begin
            step(TBL[i].lu, TBL[i].rv, TBL[i].ok, TBL[i].ty, 3'd0, TBL[i].hd, TBL[i].dt);
            check(tag_of(i), tx_valid, TBL[i].ev);
            if (TBL[i].ev)
                check(tag_of(i), tx_kind, TBL[i].et);
            check(tag_of(i), dl_up, TBL[i].eu);
            if (i == 11) begin
                // R5: first good posted record kept; bad CRC and late duplicates ignored
                check("R5 par_hdr", par_hdr_cred, {8'h00, 8'h08, 8'h20});
                check("R5 par_dat", par_dat_cred, {12'h000, 12'h010, 12'h100});
                // R8: only completion recorded as unlimited
                check("R8 hdr_inf", par_hdr_inf, 3'b100);
                check("R8 dat_inf", par_dat_inf, 3'b100);
            end
        end
        // R9: records cleared by link loss
        check("R9 par_hdr cleared", par_hdr_cred, 0);
        check("R9 par_dat cleared", par_dat_cred, 0);

        // R4 and R5 directed: local fields and channel mismatch
        step(1'b1, 1'b0, 1'b0, 4'h0, 3'd0, 8'h00, 12'h000);
        check("R4 vc", tx_vc, 0);
        check("R4 P hdr", tx_hdr, 8'h0C);
        check("R4 P dat", tx_dat, 12'h030);
        step(1'b1, 1'b1, 1'b1, 4'h4, 3'd5, 8'h3A, 12'h7FF);
        check("R4 NP hdr", tx_hdr, 8'h04);
        check("R4 NP dat", tx_dat, 12'h004);
        check("R5 vc mismatch ignored", par_hdr_cred[7:0], 8'h00);
        step(1'b1, 1'b1, 1'b1, 4'h4, 3'd0, 8'h3A, 12'h7FF);
        check("R4 Cpl hdr", tx_hdr, 8'h00);
        check("R4 Cpl dat", tx_dat, 12'h000);
        check("R5 capture hdr", par_hdr_cred[7:0], 8'h3A);
        check("R5 capture dat", par_dat_cred[11:0], 12'h7FF);
        check("R8 captured finite", {par_hdr_inf[0], par_dat_inf[0]}, 2'b00);

        // R9: loss of link in the first phase
        step(1'b0, 1'b0, 1'b0, 4'h0, 3'd0, 8'h00, 12'h000);
        check("R9 tx stops", tx_valid, 0);
        check("R9 record cleared", par_hdr_cred[7:0], 8'h00);
        check("R9 dl_up", dl_up, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule